// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block decides when a small 8-bit core accepts an interrupt and walks it through entry and return. It watches a vector of pending maskable requests, a software trap strobe and an end-of-instruction strobe. At an instruction boundary it picks the request to serve. It then writes the saved context one byte per cycle to a byte-wide stack port, sets the global mask and presents the vector address for the program counter. A return strobe at a boundary reads the context back in reverse order and clears the mask.

The same block holds the core's wait and halt low-power states. A wait strobe at a boundary parks the core until any request arrives. A halt strobe parks it until a request from a source flagged as halt-capable arrives. Instruction decode, the register file and memory are outside the block. The context to save comes in on plain input buses, and restored values leave on plain output buses.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the mask (`imask_o`) is 1, the stack pointer equals `SP_RESET`, and there is no stack access, no vector and no wake pulse.
- R2: Entry, return and low-power entry are decided only in a cycle where `instr_done_i` is 1. Pending requests never start a stack access while `instr_done_i` stays 0.
- R3: Entry writes five bytes on five consecutive cycles, in the order PC[7:0], PC[15:8], X, A, CC. The addresses are SP, SP-1, SP-2, SP-3 and SP-4, with the context sampled at the deciding boundary. The pointer ends at SP-5.
- R4: The mask reads 1 from the cycle the vector is presented. No maskable request is accepted at a boundary while the mask is 1.
- R5: Among requests pending when the mask is 0, the lowest index i is served. For one cycle `vec_valid_o` is 1, `vec_addr_o` = `VEC_BASE` - 2*i and `ack_o` has only bit i set.
- R6: A trap strobe is remembered until served, and it is served whatever the mask holds. Its vector is `TRAP_VEC`, with `trap_ack_o` = 1 and `ack_o` = 0.
- R7: A return strobe reads five bytes from SP+1 up to SP+5, in the order CC, A, X, PC[15:8], PC[7:0]. It then pulses `rest_valid_o` with the restored values, clears the mask and leaves the pointer back at its value before the matching entry.
- R8: A wait strobe at a boundary with nothing to serve sets `in_wait_o`. Any request bit clears it on the next edge and pulses `wake_o`.
- R9: A halt strobe at a boundary with nothing to serve sets `in_halt_o`. Only request bits set in `HALT_WAKE` release it, with a `wake_o` pulse. Other request bits leave it asleep.
- R10: A pending trap is served before any maskable request. Maskable requests pending during the trap routine wait until the mask is cleared.
- R11: Outside entry and return, a `mask_set_i` pulse makes the mask 1 and a `mask_clr_i` pulse makes it 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NSRC | Pending maskable requests, held by the sources |
| trap_i | input | 1 | Software trap strobe |
| instr_done_i | input | 1 | End of current instruction |
| iret_i | input | 1 | Boundary belongs to a return instruction |
| wait_i | input | 1 | Boundary belongs to a wait instruction |
| halt_i | input | 1 | Boundary belongs to a halt instruction |
| mask_set_i | input | 1 | Set the global mask |
| mask_clr_i | input | 1 | Clear the global mask |
| pc_i | input | 16 | Program counter to save |
| x_i | input | 8 | Index register to save |
| a_i | input | 8 | Accumulator to save |
| cc_i | input | 8 | Condition codes to save |
| stk_rdata_i | input | 8 | Stack read data, same cycle as address |
| stk_wr_o | output | 1 | Stack byte write |
| stk_rd_o | output | 1 | Stack byte read |
| stk_addr_o | output | SP_W | Stack byte address |
| stk_wdata_o | output | 8 | Stack write data |
| sp_o | output | SP_W | Current stack pointer |
| imask_o | output | 1 | Global mask bit |
| vec_valid_o | output | 1 | Vector address valid |
| vec_addr_o | output | 16 | Vector address for the program counter |
| ack_o | output | NSRC | One-hot acknowledge of the served request |
| trap_ack_o | output | 1 | Trap served |
| rest_valid_o | output | 1 | Restored context valid |
| rest_pc_o | output | 16 | Restored program counter |
| rest_x_o | output | 8 | Restored index register |
| rest_a_o | output | 8 | Restored accumulator |
| rest_cc_o | output | 8 | Restored condition codes |
| wake_o | output | 1 | Pulse on leaving a low-power state |
| in_wait_o | output | 1 | Core is in wait |
| in_halt_o | output | 1 | Core is in halt |

## Verification
The bench builds the block with six sources, a vector base of 0xFFEE, a trap vector of 0xFFFC and halt-capable sources 0, 2 and 5. The six sources are a width that is not a power of two. The sparse halt mask puts capable and non-capable sources next to each other, so a halt release by the wrong source shows at once. The bench nests entries about thirty deep, so the stack pointer walks through most of its byte range. With the trap vector away from the maskable vector table, a misrouted trap is told apart from source traffic.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int CTX_BYTES = 5;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_PUSH,
        ST_VEC,
        ST_POP,
        ST_WAIT,
        ST_HALT
    } seq_state_e;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int NSRC  = 8,
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]  req_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);

    // Lowest index wins: scan from the top so the lowest set bit is kept.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_wake_detect.sv
module irq_wake_detect #(
    parameter int              NSRC      = 8,
    parameter logic [NSRC-1:0] HALT_WAKE = '1
) (
    input  logic [NSRC-1:0] req_i,
    output logic            any_o,
    output logic            halt_ok_o
);

    logic [NSRC-1:0] halt_req;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        if (HALT_WAKE[g]) begin : g_cap
            assign halt_req[g] = req_i[g];
        end else begin : g_nocap
            assign halt_req[g] = 1'b0;
        end
    end

    assign any_o     = |req_i;
    assign halt_ok_o = |halt_req;

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int               NSRC      = 8,
    parameter int               SP_W      = 8,
    parameter logic [SP_W-1:0]  SP_RESET  = '1,
    parameter logic [15:0]      VEC_BASE  = 16'hFFFA,
    parameter logic [15:0]      TRAP_VEC  = 16'hFFFC,
    parameter logic [NSRC-1:0]  HALT_WAKE = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  req_i,
    input  logic             trap_i,
    input  logic             instr_done_i,
    input  logic             iret_i,
    input  logic             wait_i,
    input  logic             halt_i,
    input  logic             mask_set_i,
    input  logic             mask_clr_i,
    input  logic [15:0]      pc_i,
    input  logic [7:0]       x_i,
    input  logic [7:0]       a_i,
    input  logic [7:0]       cc_i,
    input  logic [7:0]       stk_rdata_i,
    output logic             stk_wr_o,
    output logic             stk_rd_o,
    output logic [SP_W-1:0]  stk_addr_o,
    output logic [7:0]       stk_wdata_o,
    output logic [SP_W-1:0]  sp_o,
    output logic             imask_o,
    output logic             vec_valid_o,
    output logic [15:0]      vec_addr_o,
    output logic [NSRC-1:0]  ack_o,
    output logic             trap_ack_o,
    output logic             rest_valid_o,
    output logic [15:0]      rest_pc_o,
    output logic [7:0]       rest_x_o,
    output logic [7:0]       rest_a_o,
    output logic [7:0]       rest_cc_o,
    output logic             wake_o,
    output logic             in_wait_o,
    output logic             in_halt_o
);

    localparam int IDX_W   = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam int CNT_W   = $clog2(CTX_BYTES);
    localparam int PAD_W   = 15 - IDX_W;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CTX_BYTES - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [SP_W-1:0]  sp;
        logic             imask;
        logic             trap_pend;
        logic             sel_trap;
        logic [IDX_W-1:0] sel_idx;
        logic [15:0]      ctx_pc;
        logic [7:0]       ctx_x;
        logic [7:0]       ctx_a;
        logic [7:0]       ctx_cc;
        logic             vec_valid;
        logic [15:0]      vec_addr;
        logic [NSRC-1:0]  ack;
        logic             trap_ack;
        logic             rest_valid;
        logic [15:0]      rest_pc;
        logic [7:0]       rest_x;
        logic [7:0]       rest_a;
        logic [7:0]       rest_cc;
        logic             wake;
    } seq_t;

    seq_t q, d;

    logic             pend_valid;
    logic [IDX_W-1:0] pend_idx;
    logic             wake_any;
    logic             wake_halt;
    logic             wr;
    logic             rd;
    logic [SP_W-1:0]  addr;
    logic [7:0]       wdata;

    irq_prio_enc #(.NSRC(NSRC)) u_prio (
        .req_i   (req_i),
        .valid_o (pend_valid),
        .idx_o   (pend_idx)
    );

    irq_wake_detect #(.NSRC(NSRC), .HALT_WAKE(HALT_WAKE)) u_wake (
        .req_i     (req_i),
        .any_o     (wake_any),
        .halt_ok_o (wake_halt)
    );

    always_comb begin
        d            = q;
        d.vec_valid  = 1'b0;
        d.ack        = '0;
        d.trap_ack   = 1'b0;
        d.rest_valid = 1'b0;
        d.wake       = 1'b0;
        wr           = 1'b0;
        rd           = 1'b0;
        addr         = q.sp;
        wdata        = '0;

        unique case (q.state)
            ST_RUN: begin
                if (mask_set_i) d.imask = 1'b1;
                if (mask_clr_i) d.imask = 1'b0;
                if (instr_done_i) begin
                    if (iret_i) begin
                        d.state = ST_POP;
                        d.cnt   = '0;
                    end else if (q.trap_pend || trap_i ||
                                 (pend_valid && !q.imask)) begin
                        d.state    = ST_PUSH;
                        d.cnt      = '0;
                        d.sel_trap = q.trap_pend || trap_i;
                        d.sel_idx  = pend_idx;
                        d.ctx_pc   = pc_i;
                        d.ctx_x    = x_i;
                        d.ctx_a    = a_i;
                        d.ctx_cc   = cc_i;
                    end else if (wait_i) begin
                        d.state = ST_WAIT;
                    end else if (halt_i) begin
                        d.state = ST_HALT;
                    end
                end
            end
            ST_PUSH: begin
                wr   = 1'b1;
                d.sp = q.sp - 1'b1;
                case (q.cnt)
                    CNT_W'(0): wdata = q.ctx_pc[7:0];
                    CNT_W'(1): wdata = q.ctx_pc[15:8];
                    CNT_W'(2): wdata = q.ctx_x;
                    CNT_W'(3): wdata = q.ctx_a;
                    default:   wdata = q.ctx_cc;
                endcase
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_LAST) d.state = ST_VEC;
            end
            ST_VEC: begin
                d.vec_valid = 1'b1;
                d.imask     = 1'b1;
                d.state     = ST_RUN;
                if (q.sel_trap) begin
                    d.vec_addr  = TRAP_VEC;
                    d.trap_ack  = 1'b1;
                    d.trap_pend = 1'b0;
                end else begin
                    d.vec_addr = VEC_BASE - {{PAD_W{1'b0}}, q.sel_idx, 1'b0};
                    d.ack      = NSRC'(1) << q.sel_idx;
                end
            end
            ST_POP: begin
                rd   = 1'b1;
                addr = q.sp + 1'b1;
                d.sp = q.sp + 1'b1;
                case (q.cnt)
                    CNT_W'(0): d.rest_cc       = stk_rdata_i;
                    CNT_W'(1): d.rest_a        = stk_rdata_i;
                    CNT_W'(2): d.rest_x        = stk_rdata_i;
                    CNT_W'(3): d.rest_pc[15:8] = stk_rdata_i;
                    default:   d.rest_pc[7:0]  = stk_rdata_i;
                endcase
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_LAST) begin
                    d.rest_valid = 1'b1;
                    d.imask      = 1'b0;
                    d.state      = ST_RUN;
                end
            end
            ST_WAIT: begin
                if (wake_any) begin
                    d.state = ST_RUN;
                    d.wake  = 1'b1;
                end
            end
            ST_HALT: begin
                if (wake_halt) begin
                    d.state = ST_RUN;
                    d.wake  = 1'b1;
                end
            end
            default: d.state = ST_RUN;
        endcase

        if (trap_i) d.trap_pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_RUN;
            q.sp    <= SP_RESET;
            q.imask <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign stk_wr_o     = wr;
    assign stk_rd_o     = rd;
    assign stk_addr_o   = addr;
    assign stk_wdata_o  = wdata;
    assign sp_o         = q.sp;
    assign imask_o      = q.imask;
    assign vec_valid_o  = q.vec_valid;
    assign vec_addr_o   = q.vec_addr;
    assign ack_o        = q.ack;
    assign trap_ack_o   = q.trap_ack;
    assign rest_valid_o = q.rest_valid;
    assign rest_pc_o    = q.rest_pc;
    assign rest_x_o     = q.rest_x;
    assign rest_a_o     = q.rest_a;
    assign rest_cc_o    = q.rest_cc;
    assign wake_o       = q.wake;
    assign in_wait_o    = (q.state == ST_WAIT);
    assign in_halt_o    = (q.state == ST_HALT);

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
    parameter int NSRC = 8,
    parameter int SP_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            stk_wr_o,
    input logic            stk_rd_o,
    input logic [SP_W-1:0] sp_o,
    input logic            imask_o,
    input logic            vec_valid_o,
    input logic [NSRC-1:0] ack_o,
    input logic            trap_ack_o,
    input logic            rest_valid_o,
    input logic            wake_o,
    input logic            in_wait_o,
    input logic            in_halt_o
);

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_o)); // R5
    AST_ACK_NEEDS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_o) |-> (vec_valid_o && !trap_ack_o)); // R5
    AST_TRAP_NEEDS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        trap_ack_o |-> (vec_valid_o && ack_o == '0)); // R6
    AST_VEC_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> imask_o); // R4
    AST_REST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        rest_valid_o |-> !imask_o); // R7
    AST_PUSH_SP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        stk_wr_o |=> (sp_o == SP_W'($past(sp_o) - 1'b1))); // R3
    AST_POP_SP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        stk_rd_o |=> (sp_o == SP_W'($past(sp_o) + 1'b1))); // R7
    AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_wr_o && stk_rd_o)); // R3
    AST_SLEEP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_wait_o && in_halt_o)); // R8
    AST_HALT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_halt_o) |-> wake_o); // R9
    AST_WAIT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_wait_o) |-> wake_o); // R8

endmodule

bind irq_entry_seq irq_entry_seq_chk #(.NSRC(NSRC), .SP_W(SP_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .stk_wr_o     (stk_wr_o),
    .stk_rd_o     (stk_rd_o),
    .sp_o         (sp_o),
    .imask_o      (imask_o),
    .vec_valid_o  (vec_valid_o),
    .ack_o        (ack_o),
    .trap_ack_o   (trap_ack_o),
    .rest_valid_o (rest_valid_o),
    .wake_o       (wake_o),
    .in_wait_o    (in_wait_o),
    .in_halt_o    (in_halt_o)
);

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;

    localparam int          NSRC      = 6;
    localparam int          SP_W      = 8;
    localparam logic [15:0] VEC_BASE  = 16'hFFEE;
    localparam logic [15:0] TRAP_VEC  = 16'hFFFC;
    localparam logic [5:0]  HALT_WAKE = 6'b100101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NSRC-1:0] req_i = '0;
    logic trap_i = 0, instr_done_i = 0, iret_i = 0, wait_i = 0, halt_i = 0;
    logic mask_set_i = 0, mask_clr_i = 0;
    logic [15:0] pc_i = '0;
    logic [7:0]  x_i = '0, a_i = '0, cc_i = '0;
    logic [7:0]  stk_rdata_i;
    logic stk_wr_o, stk_rd_o, imask_o, vec_valid_o, trap_ack_o, rest_valid_o;
    logic wake_o, in_wait_o, in_halt_o;
    logic [SP_W-1:0] stk_addr_o, sp_o;
    logic [7:0] stk_wdata_o, rest_x_o, rest_a_o, rest_cc_o;
    logic [15:0] vec_addr_o, rest_pc_o;
    logic [NSRC-1:0] ack_o;

    always #5 clk = ~clk;

    irq_entry_seq #(
        .NSRC(NSRC), .SP_W(SP_W), .VEC_BASE(VEC_BASE),
        .TRAP_VEC(TRAP_VEC), .HALT_WAKE(HALT_WAKE)
    ) i_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .trap_i(trap_i),
        .instr_done_i(instr_done_i), .iret_i(iret_i), .wait_i(wait_i),
        .halt_i(halt_i), .mask_set_i(mask_set_i), .mask_clr_i(mask_clr_i),
        .pc_i(pc_i), .x_i(x_i), .a_i(a_i), .cc_i(cc_i),
        .stk_rdata_i(stk_rdata_i), .stk_wr_o(stk_wr_o), .stk_rd_o(stk_rd_o),
        .stk_addr_o(stk_addr_o), .stk_wdata_o(stk_wdata_o), .sp_o(sp_o),
        .imask_o(imask_o), .vec_valid_o(vec_valid_o), .vec_addr_o(vec_addr_o),
        .ack_o(ack_o), .trap_ack_o(trap_ack_o), .rest_valid_o(rest_valid_o),
        .rest_pc_o(rest_pc_o), .rest_x_o(rest_x_o), .rest_a_o(rest_a_o),
        .rest_cc_o(rest_cc_o), .wake_o(wake_o), .in_wait_o(in_wait_o),
        .in_halt_o(in_halt_o)
    );

    // Byte-wide stack memory with same-cycle read.
    logic [7:0] mem [0:255];
    initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    always @(posedge clk) if (stk_wr_o) mem[stk_addr_o] <= stk_wdata_o;
    assign stk_rdata_i = mem[stk_addr_o];

    int checks = 0;
    int errors = 0;

    // Bench reference state.
    logic        m_mask;
    logic [7:0]  m_sp;
    logic        m_trap;
    int          depth;
    logic [15:0] fr_pc [0:63];
    logic [7:0]  fr_x [0:63], fr_a [0:63], fr_cc [0:63];

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int lowest(input logic [NSRC-1:0] r);
        for (int i = 0; i < NSRC; i++) if (r[i]) return i;
        return -1;
    endfunction

    // One instruction boundary, then observe the resulting sequence.
    task automatic boundary(input logic ret, input logic wt, input logic ht);
        logic [15:0] pc;
        logic [7:0]  x, a, cc;
        logic [7:0]  wa [0:7];
        logic [7:0]  wd [0:7];
        int nwr, nrd, src;
        logic got_vec, got_rest, exp_entry, exp_trap;
        logic [15:0] v_addr;
        logic [NSRC-1:0] v_ack;
        logic v_trap;
        logic [7:0] sp0;
        pc = 16'($urandom); x = 8'($urandom); a = 8'($urandom); cc = 8'($urandom);
        pc_i = pc; x_i = x; a_i = a; cc_i = cc;
        exp_trap  = !ret && m_trap;
        src       = lowest(req_i);
        exp_entry = !ret && (m_trap || (src >= 0 && !m_mask));
        sp0 = m_sp;
        instr_done_i = 1'b1; iret_i = ret; wait_i = wt; halt_i = ht;
        @(negedge clk);
        instr_done_i = 1'b0; iret_i = 1'b0; wait_i = 1'b0; halt_i = 1'b0;
        nwr = 0; nrd = 0; got_vec = 0; got_rest = 0;
        v_addr = '0; v_ack = '0; v_trap = 1'b0;
        for (int c = 0; c < 9; c++) begin
            if (stk_wr_o) begin
                if (nwr < 8) begin wa[nwr] = stk_addr_o; wd[nwr] = stk_wdata_o; end
                nwr++;
            end
            if (stk_rd_o) nrd++;
            if (vec_valid_o) begin
                got_vec = 1'b1; v_addr = vec_addr_o; v_ack = ack_o; v_trap = trap_ack_o;
                req_i = req_i & ~ack_o;
            end
            if (rest_valid_o) got_rest = 1'b1;
            @(negedge clk);
        end
        if (ret) begin
            depth--;
            chk(nrd == 5 && nwr == 0, "R7", "pop byte count", nrd, 5);
            chk(got_rest, "R7", "restore strobe", got_rest, 1);
            chk(rest_pc_o == fr_pc[depth], "R7", "restored pc", rest_pc_o, fr_pc[depth]);
            chk({rest_x_o, rest_a_o, rest_cc_o} == {fr_x[depth], fr_a[depth], fr_cc[depth]},
                "R7", "restored x/a/cc", {rest_x_o, rest_a_o, rest_cc_o},
                {fr_x[depth], fr_a[depth], fr_cc[depth]});
            m_sp = m_sp + 8'd5;
            m_mask = 1'b0;
            chk(imask_o == 1'b0, "R7", "mask after return", imask_o, 0);
            chk(sp_o == m_sp, "R7", "sp after return", sp_o, m_sp);
        end else if (exp_entry) begin
            chk(nwr == 5, "R3", "push byte count", nwr, 5);
            if (nwr == 5) begin
                chk(wd[0] == pc[7:0] && wa[0] == sp0, "R3", "byte0 pcl", {wa[0], wd[0]}, {sp0, pc[7:0]});
                chk(wd[1] == pc[15:8] && wa[1] == 8'(sp0 - 1), "R3", "byte1 pch", {wa[1], wd[1]}, {8'(sp0 - 1), pc[15:8]});
                chk(wd[2] == x && wa[2] == 8'(sp0 - 2), "R3", "byte2 x", {wa[2], wd[2]}, {8'(sp0 - 2), x});
                chk(wd[3] == a && wa[3] == 8'(sp0 - 3), "R3", "byte3 a", {wa[3], wd[3]}, {8'(sp0 - 3), a});
                chk(wd[4] == cc && wa[4] == 8'(sp0 - 4), "R3", "byte4 cc", {wa[4], wd[4]}, {8'(sp0 - 4), cc});
            end
            chk(got_vec, "R4", "vector presented", got_vec, 1);
            if (exp_trap) begin
                chk(v_addr == TRAP_VEC && v_trap && v_ack == '0, "R6", "trap vector",
                    v_addr, TRAP_VEC);
                m_trap = 1'b0;
            end else begin
                chk(v_addr == 16'(VEC_BASE - 16'(2 * src)) && !v_trap, "R5", "source vector",
                    v_addr, 16'(VEC_BASE - 16'(2 * src)));
                chk(v_ack == NSRC'(1 << src), "R5", "ack one-hot", v_ack, 1 << src);
            end
            fr_pc[depth] = pc; fr_x[depth] = x; fr_a[depth] = a; fr_cc[depth] = cc;
            depth++;
            m_sp = m_sp - 8'd5;
            m_mask = 1'b1;
            chk(imask_o == 1'b1, "R4", "mask set on entry", imask_o, 1);
            chk(sp_o == m_sp, "R3", "sp after push", sp_o, m_sp);
        end else begin
            chk(nwr == 0 && !got_vec, "R4", "no entry while masked/idle", nwr, 0);
            chk(in_wait_o == wt, "R8", "wait state", in_wait_o, wt);
            chk(in_halt_o == (ht && !wt), "R9", "halt state", in_halt_o, ht && !wt);
        end
    endtask

    task automatic set_mask(input logic v);
        mask_set_i = v; mask_clr_i = !v;
        @(negedge clk);
        mask_set_i = 1'b0; mask_clr_i = 1'b0;
        m_mask = v;
        chk(imask_o == v, "R11", "mask strobe", imask_o, v);
    endtask

    task automatic pulse_trap();
        trap_i = 1'b1;
        @(negedge clk);
        trap_i = 1'b0;
        m_trap = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        m_mask = 1'b1; m_sp = 8'hFF; m_trap = 1'b0; depth = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(imask_o == 1'b1, "R1", "reset mask", imask_o, 1);
        chk(sp_o == 8'hFF, "R1", "reset sp", sp_o, 8'hFF);
        chk(!stk_wr_o && !stk_rd_o && !vec_valid_o && !wake_o, "R1", "reset idle",
            {stk_wr_o, stk_rd_o, vec_valid_o, wake_o}, 0);

        // R4: masked request at a boundary is not accepted
        req_i = 6'b001000;
        boundary(1'b0, 1'b0, 1'b0);

        // R2: unmasked request without a boundary starts nothing
        set_mask(1'b0);
        for (int c = 0; c < 6; c++) begin
            chk(!stk_wr_o && !stk_rd_o, "R2", "no access without boundary", stk_wr_o, 0);
            @(negedge clk);
        end

        // R5: several pending, lowest wins; R4 nested request blocked
        req_i = 6'b101010;
        boundary(1'b0, 1'b0, 1'b0);
        boundary(1'b0, 1'b0, 1'b0);
        boundary(1'b1, 1'b0, 1'b0);
        boundary(1'b0, 1'b0, 1'b0);
        boundary(1'b1, 1'b0, 1'b0);
        req_i = '0;

        // R6: trap while masked
        set_mask(1'b1);
        pulse_trap();
        boundary(1'b0, 1'b0, 1'b0);
        boundary(1'b1, 1'b0, 1'b0);

        // R10: trap beats a pending unmasked request; request waits for the mask
        set_mask(1'b0);
        req_i = 6'b000001;
        pulse_trap();
        boundary(1'b0, 1'b0, 1'b0);
        boundary(1'b0, 1'b0, 1'b0);
        chk(req_i == 6'b000001, "R10", "request still waiting in trap", req_i, 1);
        boundary(1'b1, 1'b0, 1'b0);
        boundary(1'b0, 1'b0, 1'b0);
        chk(req_i == '0, "R10", "request served after return", req_i, 0);
        boundary(1'b1, 1'b0, 1'b0);

        // R8: wait left by a non-halt-capable source
        set_mask(1'b1);
        boundary(1'b0, 1'b1, 1'b0);
        req_i = 6'b000010;
        @(negedge clk);
        chk(wake_o && !in_wait_o, "R8", "wake from wait", {wake_o, in_wait_o}, 2);
        req_i = '0;
        @(negedge clk);

        // R9: halt ignores non-capable sources, leaves on a capable one
        boundary(1'b0, 1'b0, 1'b1);
        req_i = 6'b011010;
        repeat (4) begin
            @(negedge clk);
            chk(in_halt_o && !wake_o, "R9", "halt holds on non-capable", {in_halt_o, wake_o}, 2);
        end
        req_i = 6'b011110;
        @(negedge clk);
        chk(wake_o && !in_halt_o, "R9", "wake from halt", {wake_o, in_halt_o}, 2);
        req_i = '0;
        @(negedge clk);

        // Random mix
        for (int it = 0; it < 300; it++) begin
            int op;
            op = int'($urandom_range(0, 5));
            case (op)
                0: req_i = req_i | NSRC'($urandom);
                1: set_mask(1'($urandom));
                2: if (!m_trap && depth < 30) pulse_trap();
                3, 4: if (depth < 30) boundary(1'b0, 1'b0, 1'b0);
                default: if (depth > 0) boundary(1'b1, 1'b0, 1'b0);
            endcase
        end
        while (depth > 0) boundary(1'b1, 1'b0, 1'b0);
        chk(sp_o == 8'hFF, "R7", "sp back at top", sp_o, 8'hFF);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule